// File: doc/BRIEF.md
# Serviced Countdown Watchdog

This block counts down from a programmed timeout, one step per system clock or one step per 2048 clocks when the slow range is selected. When the count steps from one to zero it raises a one-cycle expiration request for the reset or machine-check logic. It then reloads and keeps counting, so it requests again on each later expiry until software services it.

Software services the timer by writing two keys, in order, to a service write port. The timeout input comes from a register outside the block and may change at any time. The running count and the reload value only take the new timeout when a complete service sequence arrives. The live count is brought out for read-back. Clearing the enable input freezes the count.

Top module: `swdog_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cnt_o` is 0xFFFF and `expire_o` is 0. The internal reload value also resets to 0xFFFF.
- R2: With `cfg_en`=1 and `cfg_slow`=0, `cnt_o` decreases by one after every rising clock edge until it reaches zero.
- R3: With `cfg_en`=1 and `cfg_slow`=1, `cnt_o` changes once every 2048 clock edges. The 2048-clock phase restarts when a service completes.
- R4: With `cfg_en`=0, `cnt_o` and the prescaler phase hold their values.
- R5: `expire_o` is high for exactly one cycle. That is the cycle in which `cnt_o` first shows 0 after showing 1.
- R6: A step taken at count 0 loads the reload value, and counting continues. With reload value T, expiries repeat every T+1 steps.
- R7: A change on `cfg_timeout` with no completed service changes neither the running count nor the reload value.
- R8: A service completes when a write of 0x556C is followed by a write of 0xAA39 as the next write. Idle cycles between the two writes are allowed. In the cycle after the 0xAA39 write, `cnt_o` equals `cfg_timeout`, and that value becomes the reload value.
- R9: Any other value written between 0x556C and 0xAA39 aborts the sequence. A fresh 0x556C re-arms it.
- R10: A write of 0xAA39 that does not directly follow an armed 0x556C has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Count enable |
| cfg_slow | input | 1 | Select divide-by-2048 prescaler |
| cfg_timeout | input | 16 | Programmed timeout value |
| svc_wr | input | 1 | Service word write strobe |
| svc_data | input | 16 | Service word |
| expire_o | output | 1 | One-cycle expiration request |
| cnt_o | output | 16 | Current count |

## Verification
A wrong count shows on `cnt_o` in the cycle after the faulty edge. A missing or doubled step therefore shows up at once in fast mode, and within one prescaler period of 2048 clocks in slow mode. A bad reload value or a bad service state cannot be seen until the next expiry or the next attempted service. When that happens, the period between `expire_o` pulses is wrong, or the count fails to jump to the timeout.

// File: rtl/swdog_pkg.sv
package swdog_pkg;
   typedef enum logic [0:0] {
      SVC_IDLE  = 1'b0,
      SVC_ARMED = 1'b1
   } svc_state_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/swdog_prescale.sv
module swdog_prescale #(
   parameter int unsigned DIV = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick_o
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [PW-1:0] ph_q;

   generate
      if (DIV < 2) begin : g_bad
         $error("swdog_prescale: DIV must be at least 2");
      end
      if (swdog_pkg::is_pow2(DIV)) begin : g_wrap
         assign tick_o = run && (&ph_q);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ph_q <= '0;
            else if (clr) ph_q <= '0;
            else if (run) ph_q <= ph_q + 1'b1;
         end
      end else begin : g_cmp
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         assign tick_o = run && (ph_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      ph_q <= '0;
            else if (clr)    ph_q <= '0;
            else if (tick_o) ph_q <= '0;
            else if (run)    ph_q <= ph_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/swdog_svc_seq.sv
module swdog_svc_seq #(
   parameter int unsigned      W     = 16,
   parameter logic [W-1:0]     KEY_A = 16'h556C,
   parameter logic [W-1:0]     KEY_B = 16'hAA39
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] data,
   output logic         svc_o
);
   import swdog_pkg::*;

   generate
      if (KEY_A == KEY_B) begin : g_bad
         $error("swdog_svc_seq: keys must differ");
      end
   endgenerate

   svc_state_t st_q, st_d;

   assign svc_o = wr && (st_q == SVC_ARMED) && (data == KEY_B);

   always_comb begin
      st_d = st_q;
      if (wr) st_d = (data == KEY_A) ? SVC_ARMED : SVC_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SVC_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/swdog_countdown.sv
module swdog_countdown #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt_o,
   output logic         expire_o
);
   localparam logic [W-1:0] ONE  = W'(1);
   localparam logic [W-1:0] FULL = '1;

   logic [W-1:0] cnt_q, rel_q;
   logic         exp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= FULL;
         rel_q <= FULL;
         exp_q <= 1'b0;
      end else begin
         exp_q <= 1'b0;
         if (load) begin
            cnt_q <= load_val;
            rel_q <= load_val;
         end else if (step) begin
            if (cnt_q == ONE) begin
               cnt_q <= '0;
               exp_q <= 1'b1;
            end else if (cnt_q == '0) begin
               cnt_q <= rel_q;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end
   end

   assign cnt_o    = cnt_q;
   assign expire_o = exp_q;
endmodule

// File: rtl/swdog_top.sv
module swdog_top #(
   parameter int unsigned      CNT_W   = 16,
   parameter int unsigned      PRE_DIV = 2048,
   parameter logic [CNT_W-1:0] KEY_A   = 16'h556C,
   parameter logic [CNT_W-1:0] KEY_B   = 16'hAA39
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_slow,
   input  logic [CNT_W-1:0] cfg_timeout,
   input  logic             svc_wr,
   input  logic [CNT_W-1:0] svc_data,
   output logic             expire_o,
   output logic [CNT_W-1:0] cnt_o
);
   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("swdog_top: CNT_W must be at least 2");
      end
   endgenerate

   logic svc_done, pre_tick, step;

   swdog_svc_seq #(.W(CNT_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr(svc_wr), .data(svc_data), .svc_o(svc_done)
   );

   swdog_prescale #(.DIV(PRE_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(cfg_en && cfg_slow),
      .clr(svc_done), .tick_o(pre_tick)
   );

   assign step = cfg_en && (cfg_slow ? pre_tick : 1'b1);

   swdog_countdown #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .load(svc_done),
      .load_val(cfg_timeout), .cnt_o(cnt_o), .expire_o(expire_o)
   );
endmodule

// File: rtl/swdog_chk.sv
module swdog_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_en,
   input logic             cfg_slow,
   input logic             svc_wr,
   input logic             expire_o,
   input logic [CNT_W-1:0] cnt_o
);
   // R5
   expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> !expire_o);

   // R5
   expire_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |-> (cnt_o == '0) && ($past(cnt_o) == CNT_W'(1)));

   // R4
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && !svc_wr) |=> $stable(cnt_o));

   // R2
   fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && !cfg_slow && !svc_wr && cnt_o > CNT_W'(1))
         |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));

   // R3
   slow_no_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && cfg_slow && !svc_wr && $past(cfg_slow) && cnt_o != $past(cnt_o))
         |=> $stable(cnt_o));
endmodule

bind swdog_top swdog_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_slow(cfg_slow),
   .svc_wr(svc_wr), .expire_o(expire_o), .cnt_o(cnt_o)
);

// File: tb/test_swdog_top.sv
module test_swdog_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_en = 1'b0, cfg_slow = 1'b0, svc_wr = 1'b0;
   logic [15:0] cfg_timeout = 16'h0, svc_data = 16'h0;
   logic        expire_o;
   logic [15:0] cnt_o;

   int    n_run = 0, n_fail = 0;
   string phase = "R1 reset";

   always #2 clk = ~clk;

   swdog_top i_swdog_top (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_slow(cfg_slow),
      .cfg_timeout(cfg_timeout), .svc_wr(svc_wr), .svc_data(svc_data),
      .expire_o(expire_o), .cnt_o(cnt_o)
   );

   // reference model built from the requirements
   logic [15:0] m_cnt = 16'hFFFF, m_rel = 16'hFFFF;
   int          m_pre = 0;
   bit          m_armed = 0;
   logic [16:0] exp_q[$];
   string       tag_q[$];

   task automatic push_exp(input logic [15:0] c, input logic e, input string t);
      exp_q.push_back({e, c});
      tag_q.push_back(t);
   endtask

   always @(posedge clk) begin
      bit tick, svc, e;
      if (!rst_n) begin
         m_cnt = 16'hFFFF; m_rel = 16'hFFFF; m_pre = 0; m_armed = 0;
      end else begin
         e = 0;
         svc = svc_wr && m_armed && (svc_data == 16'hAA39);
         if (svc_wr) m_armed = (svc_data == 16'h556C);
         if (svc) begin
            m_cnt = cfg_timeout; m_rel = cfg_timeout; m_pre = 0;
         end else if (cfg_en) begin
            tick = 1;
            if (cfg_slow) begin
               tick = (m_pre == 2047);
               m_pre = (m_pre + 1) % 2048;
            end
            if (tick) begin
               if (m_cnt == 16'd1) begin m_cnt = 0; e = 1; end
               else if (m_cnt == 16'd0) m_cnt = m_rel;
               else m_cnt = m_cnt - 16'd1;
            end
         end
         push_exp(m_cnt, e, phase);
      end
   end

   // monitor: compare away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [16:0] x;
         string t;
         x = exp_q.pop_front();
         t = tag_q.pop_front();
         n_run++;
         if (cnt_o !== x[15:0] || expire_o !== x[16]) begin
            n_fail++;
            $display("[TB] FAIL %s: cnt=%h exp=%b, expected cnt=%h exp=%b",
                     t, cnt_o, expire_o, x[15:0], x[16]);
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_svc(input logic [15:0] d);
      svc_wr = 1'b1; svc_data = d;
      @(negedge clk);
      svc_wr = 1'b0; svc_data = 16'h0;
   endtask

   task automatic run_all();
      // R1: reset values
      idle(2);
      n_run++;
      if (cnt_o !== 16'hFFFF || expire_o !== 1'b0) begin
         n_fail++;
         $display("[TB] FAIL R1: cnt=%h exp=%b, expected cnt=ffff exp=0", cnt_o, expire_o);
      end
      rst_n = 1'b1;
      phase = "R4 hold after reset";
      idle(10);
      // R2: fast countdown from reset value
      phase = "R2 fast step";
      cfg_timeout = 16'd5; cfg_en = 1'b1;
      idle(6);
      // R8: service with an idle cycle between keys
      phase = "R8 service";
      wr_svc(16'h556C); idle(1); wr_svc(16'hAA39);
      // R5 / R6: repeated expiry, period 6
      phase = "R5 R6 expiry and reload";
      idle(25);
      // R7: timeout change without service
      phase = "R7 unserviced timeout";
      cfg_timeout = 16'd9;
      idle(20);
      // R9: aborted sequence
      phase = "R9 abort";
      wr_svc(16'h556C); wr_svc(16'h1234); wr_svc(16'hAA39);
      idle(4);
      // R10: lone second key
      phase = "R10 lone key";
      wr_svc(16'hAA39); idle(3);
      // R9: re-arm then complete
      phase = "R9 rearm";
      wr_svc(16'h556C); wr_svc(16'h556C); wr_svc(16'hAA39);
      idle(25);
      // R4: disabled hold mid-count
      phase = "R4 disabled hold";
      cfg_en = 1'b0; idle(12); cfg_en = 1'b1; idle(5);
      // R3: slow range
      phase = "R3 slow range";
      cfg_timeout = 16'd2; cfg_slow = 1'b1;
      wr_svc(16'h556C); wr_svc(16'hAA39);
      idle(3 * 2048 * 2 + 100);
      // R4: disable in slow mode keeps prescaler phase
      phase = "R4 slow hold";
      idle(700); cfg_en = 1'b0; idle(300); cfg_en = 1'b1;
      idle(2048 * 3);
      idle(2);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            n_fail++;
            $display("[TB] FAIL watchdog: run hung, expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule